// File: doc/BRIEF.md
# Serial MSB-First Magnitude Comparator

This block decides whether one unsigned operand is strictly greater than another. It spends one clock per bit position instead of building a parallel comparison tree. A start pulse captures both operands into internal shift registers. The control then examines one bit pair per clock, beginning with the most significant bit. The scan stops at the first bit position where the operands differ, so the latency depends on the data. It is at most one clock per operand bit.

Each bit step produces a three-way code. Its low bit says "equal here, defer to the lower bits". Its high bit says "the first operand wins". The final code is held at the outputs together with a plain greater-than flag until the next operation finishes. A one-cycle done pulse marks each new result, and a busy flag covers the scan.

Top module: `serialGtCompare`

## Requirements
- R1: A synchronous active-high reset leaves busy and done at 0, status at 2'b01 and gtFlag at 0.
- R2: status uses the code {win, defer}: 2'b10 when opA > opB, 2'b00 when opA < opB and 2'b01 when they are equal. Code 2'b11 never appears. gtFlag is 1 exactly when status is 2'b10, so equal operands give gtFlag 0.
- R3: When start is high while busy is low, opA and opB are captured at that clock edge and busy is high in the following cycle.
- R4: The clock edge that captures the operands is numbered 0. done rises after edge L. L is the 1-based position, counted from the MSB, of the first bit in which the operands differ. When the operands are equal, L is WIDTH.
- R5: done is high for exactly one cycle. busy falls at the same edge that raises done, and busy never falls without done.
- R6: A start that arrives while busy is high is ignored. The running operation keeps its operands, its result and its latency.
- R7: Changes on opA and opB after the capture edge do not affect the running operation.
- R8: status and gtFlag keep their values in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to capture operands and begin a comparison |
| opA | input | WIDTH | First operand, unsigned |
| opB | input | WIDTH | Second operand, unsigned |
| busy | output | 1 | A comparison is in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| gtFlag | output | 1 | 1 when the latest result was opA > opB |
| status | output | 2 | Latest three-way result code {win, defer} |

## Verification
Every result is due a data-dependent number of edges after the capture edge. That number is the position of the first differing bit counted from the MSB, or WIDTH for equal operands. The driver records the capture edge number together with the expected code and this latency. When done is seen, the monitor computes the elapsed edge count from a free-running cycle counter and compares it with the recorded latency. All pairs are swept at WIDTH 4 and random pairs plus corner pairs at WIDTH 8. Busy is sampled one cycle after capture. Status is checked across idle cycles after a result for hold.

// File: rtl/serCmpPkg.sv
package serCmpPkg;

  typedef logic [1:0] stat_t;

  // {win, defer}: defer=1 hands the decision to the less significant bits
  localparam stat_t STAT_LESS    = 2'b00;
  localparam stat_t STAT_EQUAL   = 2'b01;
  localparam stat_t STAT_GREATER = 2'b10;

  typedef struct packed {
    logic load;   // capture operands into the shift registers
    logic step;   // advance the scan by one bit
    logic latch;  // store the current bit code as the final result
  } strobes_t;

endpackage

// File: rtl/serCmpBit.sv
module serCmpBit
  import serCmpPkg::*;
(
  input  logic  aBit,
  input  logic  bBit,
  output stat_t code
);

  always_comb begin
    if (aBit && !bBit) begin
      code = STAT_GREATER;
    end else if (!aBit && bBit) begin
      code = STAT_LESS;
    end else begin
      code = STAT_EQUAL;
    end
  end

endmodule

// File: rtl/serCmpData.sv
module serCmpData
  import serCmpPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output stat_t            headCode,
  output stat_t            resCode
);

  logic [WIDTH-1:0] aShift;
  logic [WIDTH-1:0] bShift;

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      aShift <= opA;
      bShift <= opB;
    end else if (strobes.step) begin
      aShift <= {aShift[WIDTH-2:0], 1'b0};
      bShift <= {bShift[WIDTH-2:0], 1'b0};
    end
  end

  serCmpBit uBit (
    .aBit (aShift[WIDTH-1]),
    .bBit (bShift[WIDTH-1]),
    .code (headCode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resCode <= STAT_EQUAL;
    end else if (strobes.latch) begin
      resCode <= headCode;
    end
  end

endmodule

// File: rtl/serCmpCtrl.sv
module serCmpCtrl
  import serCmpPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  stat_t    headCode,
  output strobes_t strobes,
  output logic     busy,
  output logic     done
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] bitsLeft;
  logic          lastStep;

  always_comb begin
    lastStep      = busy && ((headCode != STAT_EQUAL) || (bitsLeft == '0));
    strobes.load  = start && !busy;
    strobes.step  = busy;
    strobes.latch = lastStep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      bitsLeft <= '0;
    end else begin
      done <= lastStep;
      if (strobes.load) begin
        busy     <= 1'b1;
        bitsLeft <= LAST_IDX;
      end else if (lastStep) begin
        busy <= 1'b0;
      end else if (busy) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

endmodule

// File: rtl/serialGtCompare.sv
module serialGtCompare
  import serCmpPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic             gtFlag,
  output logic [1:0]       status
);

  strobes_t strobes;
  stat_t    headCode;
  stat_t    resCode;

  serCmpCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .headCode (headCode),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  serCmpData #(.WIDTH(WIDTH)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .headCode (headCode),
    .resCode  (resCode)
  );

  assign status = resCode;
  assign gtFlag = resCode[1];

endmodule

// File: rtl/serialGtCompareChk.sv
module serialGtCompareChk #(
  parameter int WIDTH = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status
);

  localparam int LW = $clog2(WIDTH + 2) + 1;
  localparam logic [LW-1:0] LIMIT = LW'(WIDTH);

  logic [LW-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      busyLen <= '0;
    end else begin
      busyLen <= busyLen + 1'b1;
    end
  end

  p_status_legal_r2: assert property (@(posedge clk) disable iff (rst)
    status != 2'b11);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_latency_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busyLen < LIMIT));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_ends_done_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(status));

endmodule

bind serialGtCompare serialGtCompareChk #(.WIDTH(WIDTH)) uChk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .status (status)
);

// File: tb/sim_serialGtCompare.sv
module sim_serialGtCompare;

  typedef struct {
    logic [1:0] code;
    int         lat;
    int         startEdge;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  logic       start0 = 1'b0;
  logic [7:0] a0 = '0, b0 = '0;
  logic       busy0, done0, gt0;
  logic [1:0] stat0;

  logic       start1 = 1'b0;
  logic [3:0] a1 = '0, b1 = '0;
  logic       busy1, done1, gt1;
  logic [1:0] stat1;

  serialGtCompare #(.WIDTH(8)) u0 (
    .clk(clk), .rst(rst), .start(start0), .opA(a0), .opB(b0),
    .busy(busy0), .done(done0), .gtFlag(gt0), .status(stat0));

  serialGtCompare #(.WIDTH(4)) u1 (
    .clk(clk), .rst(rst), .start(start1), .opA(a1), .opB(b1),
    .busy(busy1), .done(done1), .gtFlag(gt1), .status(stat1));

  exp_t q0[$];
  exp_t q1[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [1:0] expCode(input logic [7:0] a, input logic [7:0] b);
    if (a > b) return 2'b10;
    if (a < b) return 2'b00;
    return 2'b01;
  endfunction

  function automatic int expLat(input logic [7:0] a, input logic [7:0] b, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      if (a[i] != b[i]) return w - i;
    end
    return w;
  endfunction

  // Driver for the 8-bit unit; operands are scrambled after capture (R7)
  task automatic drive8(input logic [7:0] a, input logic [7:0] b);
    exp_t it;
    @(negedge clk);
    while (busy0) @(negedge clk);
    a0 = a; b0 = b; start0 = 1'b1;
    it.code = expCode(a, b); it.lat = expLat(a, b, 8); it.startEdge = cyc + 1;
    q0.push_back(it);
    @(negedge clk);
    start0 = 1'b0; a0 = ~a; b0 = b ^ 8'h5A;
    check(busy0 == 1'b1, "R3 busy after start (W8)", busy0, 1);
  endtask

  task automatic drive4(input logic [3:0] a, input logic [3:0] b);
    exp_t it;
    @(negedge clk);
    while (busy1) @(negedge clk);
    a1 = a; b1 = b; start1 = 1'b1;
    it.code = expCode({4'h0, a}, {4'h0, b}); it.lat = expLat({4'h0, a}, {4'h0, b}, 4);
    it.startEdge = cyc + 1;
    q1.push_back(it);
    @(negedge clk);
    start1 = 1'b0; a1 = ~a; b1 = b ^ 4'h9;
  endtask

  // Monitors: compare code, flag and latency (R2, R4, R5)
  logic prevDone0 = 1'b0, prevDone1 = 1'b0;
  exp_t m0, m1;

  always @(negedge clk) begin
    if (!rst) begin
      if (prevDone0 && done0) check(1'b0, "R5 done longer than one cycle (W8)", 1, 0);
      if (done0) begin
        if (q0.size() == 0) begin
          check(1'b0, "R6 unexpected result (W8)", 1, 0);
        end else begin
          m0 = q0.pop_front();
          check(stat0 == m0.code, "R2 status (W8)", stat0, m0.code);
          check(gt0 == (m0.code == 2'b10), "R2 gtFlag (W8)", gt0, m0.code == 2'b10);
          check(cyc - m0.startEdge == m0.lat, "R4 latency (W8)", cyc - m0.startEdge, m0.lat);
          check(busy0 == 1'b0, "R5 busy low with done (W8)", busy0, 0);
        end
      end
      if (prevDone1 && done1) check(1'b0, "R5 done longer than one cycle (W4)", 1, 0);
      if (done1) begin
        if (q1.size() == 0) begin
          check(1'b0, "R6 unexpected result (W4)", 1, 0);
        end else begin
          m1 = q1.pop_front();
          check(stat1 == m1.code, "R2 status (W4)", stat1, m1.code);
          check(gt1 == (m1.code == 2'b10), "R2 gtFlag (W4)", gt1, m1.code == 2'b10);
          check(cyc - m1.startEdge == m1.lat, "R4 latency (W4)", cyc - m1.startEdge, m1.lat);
          check(busy1 == 1'b0, "R5 busy low with done (W4)", busy1, 0);
        end
      end
    end
    prevDone0 = done0;
    prevDone1 = done1;
  end

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0 || busy0 || busy1) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0 pending", q0.size() + q1.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] held;
    logic       heldGt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(busy0 == 0 && done0 == 0, "R1 busy/done after reset", {busy0, done0}, 0);
    check(stat0 == 2'b01, "R1 status after reset", stat0, 1);
    check(gt0 == 1'b0, "R1 gtFlag after reset", gt0, 0);
    check(stat1 == 2'b01 && busy1 == 0, "R1 W4 reset state", {busy1, stat1}, 1);

    // corner pairs: MSB decides, LSB decides, equal, all-ones
    drive8(8'h80, 8'h7F);
    drive8(8'h7F, 8'h80);
    drive8(8'h01, 8'h00);
    drive8(8'h00, 8'h01);
    drive8(8'hFF, 8'hFF);
    drive8(8'h00, 8'h00);
    drive8(8'hA5, 8'hA4);
    drain();

    // R6: start during a long scan is ignored
    drive8(8'h01, 8'h00);
    @(negedge clk);
    start0 = 1'b1; a0 = 8'h00; b0 = 8'h80;
    @(negedge clk);
    start0 = 1'b0;
    drain();
    check(stat0 == 2'b10, "R6 ignored start kept result", stat0, 2);

    // R8: result held while done is low
    held = stat0; heldGt = gt0;
    repeat (6) @(negedge clk);
    check(stat0 == held && gt0 == heldGt, "R8 status held", stat0, held);
    a0 = 8'h00; b0 = 8'hFF;
    repeat (3) @(negedge clk);
    check(stat0 == held, "R8 held under operand change", stat0, held);

    // exhaustive at WIDTH 4
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        drive4(4'(x), 4'(y));
      end
    end
    // random at WIDTH 8
    for (int k = 0; k < 400; k++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = (k % 4 == 0) ? (ra ^ 8'(1 << (k % 8))) : 8'($urandom);
      drive8(ra, rb);
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule